// File: doc/BRIEF.md
# Peripheral Event Router with DMA Start Vectors

This block stands between a handful of peripheral event sources and the interrupt controller. Each source raises a pulse that carries a fixed vector code. The codes are 0x10 to 0x13 for the four timers and 0x19 for the serial receiver. Software loads up to four byte-wide start-vector registers, one for each DMA channel. An event whose code equals one of those registers starts that DMA channel and never becomes an interrupt. An event with no matching register is passed on as a pending-set request for its interrupt source.

Events are first captured in one request latch per source. Each cycle the router takes the latched request with the lowest vector code. It compares that code with the four registers and the lowest-numbered matching channel wins. The result is registered, so every decision appears on the outputs as a pulse that lasts exactly one cycle. The pulse is either a one-hot DMA start or an interrupt-set strobe with the source index. If several sources fire at once, they drain one per cycle in code order.

Top module: `evdisp_router`

## Requirements
- R1: After synchronous reset all start-vector registers hold 0, no request is latched, and `dma_start`, `irq_set` are low. An event arriving with the reset register contents becomes an interrupt request.
- R2: A write with `cfg_we` high loads `cfg_data` into the register of channel `cfg_sel`, and leaves the other registers unchanged. A later write to the same channel replaces the earlier value.
- R3: When the served event's code equals a channel register, exactly one bit of `dma_start` is high (bit n for channel n), and `irq_set` stays low in that cycle.
- R4: When several channel registers hold the served code, only the lowest-numbered of them is started.
- R5: When no register matches, `irq_set` pulses with `dma_start` all zero. `irq_idx` is 7, 8, 9 or 10 for timer 0 to 3 (codes 0x10 to 0x13), and 12 for serial receive (code 0x19).
- R6: An event sampled high at rising edge k is latched at k. Its result is registered at edge k+1 and holds for exactly the one cycle that follows, provided no lower-code request is waiting.
- R7: Events on several inputs in one cycle are served one per cycle in ascending code order, which is input bit order: `evt_in[0]` timer 0 up to `evt_in[4]` serial receive.
- R8: Each source's latch holds at most one request. A new event on a source whose request is still waiting merges into that request and is delivered once. A new event that arrives in the cycle its request is served is latched again and delivered a second time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Start-vector register write strobe |
| cfg_sel | input | 2 | DMA channel whose register is written |
| cfg_data | input | 8 | Vector code to store |
| evt_in | input | 5 | Event pulses: bits 0-3 timers 0-3, bit 4 serial receive |
| dma_start | output | 4 | One-cycle one-hot DMA channel start |
| irq_set | output | 1 | One-cycle interrupt pending-set strobe |
| irq_idx | output | 5 | Interrupt source index qualified by `irq_set` |

## Verification
A corrupted start-vector register shows up on the first event whose code it should or should not match. The event goes to the wrong DMA channel or turns into an interrupt, and this appears two edges after the event. A wrong request latch gives one of three symptoms: a missing pulse, a duplicate pulse, or pulses out of code order. These show up within one cycle per waiting source. The bench therefore sweeps every source against every pattern of matching channels and compares each output pulse and the idle cycle after it. It also drives simultaneous, merged and re-arriving events and checks the drain order cycle by cycle.

// File: rtl/evdisp_pkg.sv
package evdisp_pkg;

    localparam int NUM_CH   = 4;
    localparam int VEC_W    = 8;
    localparam int NUM_SRC  = 5;
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int SEL_W    = $clog2(NUM_CH);
    localparam int IRQ_W    = 5;

    typedef logic [VEC_W-1:0] vec_t;

    // Lowest-code waiting request
    typedef struct packed {
        logic             hit;
        logic [SRC_W-1:0] src;
    } pick_t;

    // One routing decision
    typedef struct packed {
        logic [NUM_CH-1:0] dma;
        logic              irq;
        logic [IRQ_W-1:0]  idx;
    } route_t;

    // Vector code carried by each source: timers count up from 0x10, serial is 0x19
    function automatic vec_t src_code(input logic [SRC_W-1:0] s);
        if (s == SRC_W'(NUM_SRC - 1))
            return vec_t'(8'h19);
        return vec_t'(8'h10) + vec_t'(s);
    endfunction

    // Interrupt source fed by each event: timers land on 7..10, serial on 12
    function automatic logic [IRQ_W-1:0] src_irq(input logic [SRC_W-1:0] s);
        if (s == SRC_W'(NUM_SRC - 1))
            return IRQ_W'(12);
        return IRQ_W'(7) + IRQ_W'(s);
    endfunction

endpackage

// File: rtl/evdisp_vecregs.sv
module evdisp_vecregs
    import evdisp_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int VW  = VEC_W,
    localparam int SW = $clog2(NCH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [SW-1:0]          sel,
    input  logic [VW-1:0]          wdata,
    output logic [NCH-1:0][VW-1:0] vecs
);

    for (genvar c = 0; c < NCH; c++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                vecs[c] <= '0;
            else if (we && sel == SW'(c))
                vecs[c] <= wdata;
        end
    end

endmodule

// File: rtl/evdisp_arb.sv
module evdisp_arb
    import evdisp_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic [NSRC-1:0] pend,
    output pick_t           pick
);

    // Bit order equals ascending code order; the lowest set bit wins
    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick.hit = 1'b1;
                pick.src = SRC_W'(i);
            end
        end
    end

endmodule

// File: rtl/evdisp_match.sv
module evdisp_match
    import evdisp_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int VW  = VEC_W
) (
    input  logic [NCH-1:0][VW-1:0] vecs,
    input  logic [VW-1:0]          code,
    output logic [NCH-1:0]         onehot,
    output logic                   any
);

    logic [NCH-1:0] eq;

    for (genvar c = 0; c < NCH; c++) begin : g_cmp
        assign eq[c] = (vecs[c] == code);
    end

    // Channel 0 has precedence over higher channels
    always_comb begin
        onehot = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (eq[c]) begin
                onehot    = '0;
                onehot[c] = 1'b1;
            end
        end
    end

    assign any = |eq;

endmodule

// File: rtl/evdisp_router.sv
module evdisp_router
    import evdisp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [VEC_W-1:0]   cfg_data,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic [NUM_CH-1:0]  dma_start,
    output logic               irq_set,
    output logic [IRQ_W-1:0]   irq_idx
);

    logic [NUM_CH-1:0][VEC_W-1:0] vecs;
    logic [NUM_SRC-1:0]           pend;
    logic [NUM_SRC-1:0]           served;
    pick_t                        pick;
    logic [NUM_CH-1:0]            hit_oh;
    logic                         hit_any;
    route_t                       route_d;
    route_t                       route_q;

    evdisp_vecregs #(.NCH(NUM_CH), .VW(VEC_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_data),
        .vecs  (vecs)
    );

    evdisp_arb #(.NSRC(NUM_SRC)) u_arb (
        .pend (pend),
        .pick (pick)
    );

    evdisp_match #(.NCH(NUM_CH), .VW(VEC_W)) u_match (
        .vecs   (vecs),
        .code   (src_code(pick.src)),
        .onehot (hit_oh),
        .any    (hit_any)
    );

    always_comb begin
        served = '0;
        if (pick.hit)
            served[pick.src] = 1'b1;
    end

    // Per-source request latches: the served bit clears, a new event re-arms
    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else
            pend <= (pend & ~served) | evt_in;
    end

    always_comb begin
        route_d     = '0;
        route_d.dma = pick.hit ? hit_oh : '0;
        route_d.irq = pick.hit && !hit_any;
        route_d.idx = src_irq(pick.src);
    end

    always_ff @(posedge clk) begin
        if (rst)
            route_q <= '0;
        else
            route_q <= route_d;
    end

    assign dma_start = route_q.dma;
    assign irq_set   = route_q.irq;
    assign irq_idx   = route_q.idx;

    // R3
    dma_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dma_start));

    // R3
    dest_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(irq_set && (|dma_start)));

    // R5
    irq_idx_chk: assert property (@(posedge clk) disable iff (rst)
        irq_set |-> (irq_idx inside {5'd7, 5'd8, 5'd9, 5'd10, 5'd12}));

    // R6
    served_next_chk: assert property (@(posedge clk) disable iff (rst)
        (|pend) |=> (irq_set || (|dma_start)));

    // R6
    pulse_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_set || (|dma_start)) |-> $past(|pend));

    // R8
    drain_one_chk: assert property (@(posedge clk) disable iff (rst)
        ((|pend) && evt_in == '0) |=> ($countones(pend) == $countones($past(pend)) - 1));

endmodule

// File: tb/tb_evdisp_router.sv
module tb_evdisp_router;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [1:0] cfg_sel;
    logic [7:0] cfg_data;
    logic [4:0] evt_in;
    logic [3:0] dma_start;
    logic       irq_set;
    logic [4:0] irq_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    evdisp_router dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .evt_in    (evt_in),
        .dma_start (dma_start),
        .irq_set   (irq_set),
        .irq_idx   (irq_idx)
    );

    function automatic logic [7:0] code_of(int s);
        return (s == 4) ? 8'h19 : 8'(8'h10 + s);
    endfunction

    function automatic logic [4:0] irq_of(int s);
        return (s == 4) ? 5'd12 : 5'(7 + s);
    endfunction

    task automatic chk(string req, logic [3:0] ed, logic ei, logic [4:0] ex);
        n_cmp++;
        if (dma_start !== ed || irq_set !== ei || (ei && irq_idx !== ex)) begin
            n_bad++;
            $display("FAIL %s: dma=%b irq=%b idx=%0d expected dma=%b irq=%b idx=%0d",
                     req, dma_start, irq_set, irq_idx, ed, ei, ex);
        end
    endtask

    task automatic wr(int ch, logic [7:0] v);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_sel  = 2'(ch);
        cfg_data = v;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    // Returns in the cycle that carries the first registered result
    task automatic send(logic [4:0] m);
        @(negedge clk);
        evt_in = m;
        @(negedge clk);
        evt_in = '0;
        @(negedge clk);
    endtask

    initial begin
        rst      = 1'b1;
        cfg_we   = 1'b0;
        cfg_sel  = '0;
        cfg_data = '0;
        evt_in   = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: idle after reset, reset vectors route to interrupts
        chk("R1", 4'b0, 1'b0, 5'd0);
        send(5'b10000);
        chk("R1", 4'b0, 1'b1, 5'd12);

        // R3 R4 R5 R6: every source against every pattern of matching channels
        for (int s = 0; s < 5; s++) begin
            for (int m = 0; m < 16; m++) begin
                for (int c = 0; c < 4; c++)
                    wr(c, m[c] ? code_of(s) : code_of((s + 1) % 5));
                send(5'(1 << s));
                if (m == 0)
                    chk("R5", 4'b0, 1'b1, irq_of(s));
                else
                    chk("R4", 4'(m & -m), 1'b0, 5'd0);
                @(negedge clk);
                chk("R6", 4'b0, 1'b0, 5'd0);
            end
        end

        // R2: overwrite replaces earlier value
        for (int c = 0; c < 4; c++) wr(c, 8'h00);
        wr(1, 8'h11);
        wr(1, 8'h13);
        send(5'b00010);
        chk("R2", 4'b0, 1'b1, 5'd8);
        send(5'b01000);
        chk("R2", 4'b0010, 1'b0, 5'd0);

        // R7: all sources at once, channel 2 takes timer 2
        wr(1, 8'h00);
        wr(2, 8'h12);
        send(5'b11111);
        chk("R7", 4'b0, 1'b1, 5'd7);
        @(negedge clk); chk("R7", 4'b0, 1'b1, 5'd8);
        @(negedge clk); chk("R7", 4'b0100, 1'b0, 5'd0);
        @(negedge clk); chk("R7", 4'b0, 1'b1, 5'd10);
        @(negedge clk); chk("R7", 4'b0, 1'b1, 5'd12);
        @(negedge clk); chk("R7", 4'b0, 1'b0, 5'd0);

        // R8: repeat on a waiting source merges
        wr(2, 8'h00);
        @(negedge clk); evt_in = 5'b00011;
        @(negedge clk); evt_in = 5'b00010;
        @(negedge clk); evt_in = 5'b00000;
        chk("R8", 4'b0, 1'b1, 5'd7);
        @(negedge clk); chk("R8", 4'b0, 1'b1, 5'd8);
        @(negedge clk); chk("R8", 4'b0, 1'b0, 5'd0);

        // R8: repeat on the serve edge is delivered again
        @(negedge clk); evt_in = 5'b00001;
        @(negedge clk); evt_in = 5'b00001;
        @(negedge clk); evt_in = 5'b00000;
        chk("R8", 4'b0, 1'b1, 5'd7);
        @(negedge clk); chk("R8", 4'b0, 1'b1, 5'd7);
        @(negedge clk); chk("R8", 4'b0, 1'b0, 5'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule